// File: doc/BRIEF.md
# Multi-Mode 16-bit PWM Timer

A 16-bit timer/counter whose counting sequence, top value, compare-update point, overflow point and pin behaviour all come from one 4-bit mode field. It covers a free-running counter, two clear-on-match variants, single-slope fast PWM and two dual-slope PWM flavours (phase correct, with compare values taken at the top, and phase-and-frequency correct, with compare values taken at the bottom). Two compare channels, A and B, each drive one waveform pin under a 2-bit output-mode field.

The counter advances only on cycles where `tick` is high, so a prescaler outside the block sets the rate. Compare registers are written through a hold stage. Depending on the mode, the value reaches the active comparator on the next clock or at the mode's update point. A third register, written directly, supplies the top value in the modes that take it from there. All outputs are registered. The three flags pulse for one cycle after the tick on which their event was seen.

Top module: `mpt_pwm_timer`

## Requirements
- R1: After a synchronous reset the count, direction, both pins, all three flags, both compare registers and the top register are zero.
- R2: Modes 0 and 13 count 0 to 0xFFFF and wrap. The overflow flag pulses after the tick taken at 0xFFFF. Compare writes reach the comparator on the next clock.
- R3: Mode 4 (top = active compare A) and mode 12 (top = top register) clear the count to 0 on the tick taken at top. Overflow pulses only after a tick at 0xFFFF. Compare writes act on the next clock.
- R4: Fast PWM wraps from top to 0. Mode 5 uses top 0x00FF, mode 6 uses 0x01FF, mode 7 uses 0x03FF, mode 14 uses the top register and mode 15 uses active compare A. The period is top+1 ticks, and overflow pulses after the tick taken at top.
- R5: Dual-slope modes count up to top and back down to 0, one tick at each end, for a period of 2×top ticks. Phase-correct modes are 1, 2 and 3 (tops 0x00FF, 0x01FF, 0x03FF), 10 (top register) and 11 (compare A). Phase-and-frequency-correct modes are 8 (top register) and 9 (compare A). Overflow pulses after the tick taken at 0.
- R6: A written compare value becomes active after the tick taken at top in fast PWM and phase-correct modes, and after the tick taken at 0 in phase-and-frequency-correct modes. Until then, matches use the previous value.
- R7: A match flag pulses for one cycle after any tick whose count equals that channel's active compare value, in every mode.
- R8: In modes 0, 4, 12 and 13, a match makes the pin toggle under output mode 1, go low under 2 and go high under 3. Output mode 0 leaves it unchanged.
- R9: In fast PWM, output mode 2 drives the pin high on the tick at top and low on a match (the top action wins when both occur). Output mode 3 does the opposite. Output modes 0 and 1 leave the pin unchanged.
- R10: In dual-slope modes, a tick counts as counting up when the next step goes up: always at 0, never at or above top, otherwise the opposite of the current direction. Output mode 2 drives the pin low on a match while counting up and high on a match while counting down. Output mode 3 does the reverse.
- R11: In dual-slope modes with output mode 1, pin A toggles on a match only in modes 8 to 11. Pin B, and pin A in modes 1 to 3, stay unchanged.
- R12: In a dual-slope mode whose output mode has bit 1 set, when the active compare value equals top, every tick drives the pin to the full-duty level: high for output mode 2, low for output mode 3.
- R13: On a cycle with `tick` low, the count and pins hold and no flag pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable for this cycle |
| mode | input | 4 | Timer mode |
| out_mode_a | input | 2 | Output mode of channel A |
| out_mode_b | input | 2 | Output mode of channel B |
| cmp_a_we | input | 1 | Write strobe, compare A |
| cmp_a_data | input | 16 | Write data, compare A |
| cmp_b_we | input | 1 | Write strobe, compare B |
| cmp_b_data | input | 16 | Write data, compare B |
| cap_top_we | input | 1 | Write strobe, top register |
| cap_top_data | input | 16 | Write data, top register |
| wave_a | output | 1 | Waveform pin A |
| wave_b | output | 1 | Waveform pin B |
| ovf_flag | output | 1 | Overflow event pulse |
| match_a | output | 1 | Channel A match pulse |
| match_b | output | 1 | Channel B match pulse |

## Verification
Directed runs measure periods and duty: a full 16-bit wrap in mode 0, a 256-tick fast PWM period with 64 high ticks, a 510-tick dual-slope period with 200 high ticks, and a 10-tick CTC toggle. These measurements separate wrap-at-top from wrap-at-MAX, and match-up from match-down. Compare writes made in mid-period show whether a mode is buffered, because matches must keep using the old value until the update point. Compare equal to top, and output mode 1 in modes 2 and 10, cover the full-duty special case and the channel-A-only toggle. Random runs cover every mode with random output modes, tick gaps and compare/top writes at random times, and check each output every cycle against a bench model.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
  localparam int CNT_W = 16;

  typedef enum logic [2:0] {K_NORM, K_CTC, K_FAST, K_PC, K_PFC} kind_t;

  function automatic kind_t kind_of(input logic [3:0] m);
    case (m)
      4'd4, 4'd12:                     return K_CTC;
      4'd5, 4'd6, 4'd7, 4'd14, 4'd15:  return K_FAST;
      4'd1, 4'd2, 4'd3, 4'd10, 4'd11:  return K_PC;
      4'd8, 4'd9:                      return K_PFC;
      default:                         return K_NORM;
    endcase
  endfunction

  function automatic logic is_dual(input kind_t k);
    return (k == K_PC) || (k == K_PFC);
  endfunction

  function automatic logic is_immediate(input kind_t k);
    return (k == K_NORM) || (k == K_CTC);
  endfunction

  // fixed tops 0x00FF / 0x01FF / 0x03FF come from the low two mode bits
  function automatic logic [CNT_W-1:0] top_of(input logic [3:0] m,
                                              input logic [CNT_W-1:0] cmpa,
                                              input logic [CNT_W-1:0] cap);
    logic [CNT_W-1:0] fixed;
    fixed = (CNT_W'(1) << (7 + int'(m[1:0]))) - CNT_W'(1);
    case (m)
      4'd1, 4'd2, 4'd3, 4'd5, 4'd6, 4'd7: return fixed;
      4'd4, 4'd9, 4'd11, 4'd15:           return cmpa;
      4'd8, 4'd10, 4'd12, 4'd14:          return cap;
      default:                            return '1;
    endcase
  endfunction
endpackage

// File: rtl/mpt_counter.sv
module mpt_counter import mpt_pkg::*; #(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  kind_t        kind,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         down,
  output logic         up_next,
  output logic         at_top,
  output logic         at_bot,
  output logic         at_max
);
  localparam logic [W-1:0] ONE = W'(1);

  logic         dual;
  logic [W-1:0] cnt_nx;

  always_comb begin
    dual   = is_dual(kind);
    at_top = (cnt == top);
    at_bot = (cnt == '0);
    at_max = &cnt;
    if (!dual)           up_next = 1'b1;
    else if (cnt >= top) up_next = 1'b0;
    else if (at_bot)     up_next = 1'b1;
    else                 up_next = ~down;
    if (!dual)           cnt_nx = at_top ? '0 : cnt + ONE;
    else if (up_next)    cnt_nx = cnt + ONE;
    else                 cnt_nx = at_bot ? '0 : cnt - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (tick) begin
      cnt  <= cnt_nx;
      down <= dual & ~up_next;
    end
  end
endmodule

// File: rtl/mpt_cmpbuf.sv
module mpt_cmpbuf #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] din,
  input  logic         imm,
  input  logic         load,
  output logic [W-1:0] act
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      act    <= '0;
    end else begin
      if (wr) hold_q <= din;
      if (imm)       act <= wr ? din : hold_q;
      else if (load) act <= hold_q;
    end
  end
endmodule

// File: rtl/mpt_wave.sv
module mpt_wave import mpt_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  kind_t      kind,
  input  logic [1:0] om,
  input  logic       tog_en,
  input  logic       hit,
  input  logic       hit_top,
  input  logic       at_top,
  input  logic       up_next,
  output logic       pin
);
  logic nx;

  always_comb begin
    nx = pin;
    case (kind)
      K_NORM, K_CTC: begin
        if (hit) begin
          case (om)
            2'd1:    nx = ~pin;
            2'd2:    nx = 1'b0;
            2'd3:    nx = 1'b1;
            default: nx = pin;
          endcase
        end
      end
      K_FAST: begin
        if (om[1]) begin
          if (at_top)   nx = ~om[0];
          else if (hit) nx = om[0];
        end
      end
      default: begin
        if (om[1] && hit_top)               nx = ~om[0];
        else if (om[1] && hit)              nx = up_next ? om[0] : ~om[0];
        else if (om == 2'd1 && tog_en && hit) nx = ~pin;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       pin <= 1'b0;
    else if (tick) pin <= nx;
  end
endmodule

// File: rtl/mpt_pwm_timer.sv
module mpt_pwm_timer import mpt_pkg::*; #(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [3:0]   mode,
  input  logic [1:0]   out_mode_a,
  input  logic [1:0]   out_mode_b,
  input  logic         cmp_a_we,
  input  logic [W-1:0] cmp_a_data,
  input  logic         cmp_b_we,
  input  logic [W-1:0] cmp_b_data,
  input  logic         cap_top_we,
  input  logic [W-1:0] cap_top_data,
  output logic         wave_a,
  output logic         wave_b,
  output logic         ovf_flag,
  output logic         match_a,
  output logic         match_b
);
  localparam int NCH = 2;

  kind_t                  kind;
  logic [W-1:0]           cnt_q, top_val, cap_q;
  logic                   cnt_down, up_next, at_top, at_bot, at_max;
  logic                   evt_ovf, cmp_load;
  logic [NCH-1:0][W-1:0]  act_v;
  logic [NCH-1:0]         hit_v, pin_v;
  logic [W-1:0]           cmp_a_act, cmp_b_act;

  assign kind      = kind_of(mode);
  assign top_val   = top_of(mode, act_v[0], cap_q);
  assign cmp_a_act = act_v[0];
  assign cmp_b_act = act_v[1];

  always_ff @(posedge clk) begin
    if (rst)             cap_q <= '0;
    else if (cap_top_we) cap_q <= cap_top_data;
  end

  mpt_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .kind(kind), .top(top_val),
    .cnt(cnt_q), .down(cnt_down), .up_next(up_next),
    .at_top(at_top), .at_bot(at_bot), .at_max(at_max)
  );

  always_comb begin
    case (kind)
      K_NORM, K_CTC: evt_ovf = at_max;
      K_FAST:        evt_ovf = at_top;
      default:       evt_ovf = at_bot;
    endcase
    cmp_load = tick && ((((kind == K_FAST) || (kind == K_PC)) && at_top) ||
                        ((kind == K_PFC) && at_bot));
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic         we, tog, hit_top;
    logic [W-1:0] din;
    logic [1:0]   om;
    assign we      = (c == 0) ? cmp_a_we   : cmp_b_we;
    assign din     = (c == 0) ? cmp_a_data : cmp_b_data;
    assign om      = (c == 0) ? out_mode_a : out_mode_b;
    assign tog     = (c == 0) && (mode[3:2] == 2'b10);
    assign hit_v[c] = (cnt_q == act_v[c]);
    assign hit_top  = (act_v[c] == top_val);

    mpt_cmpbuf #(.W(W)) u_buf (
      .clk(clk), .rst(rst), .wr(we), .din(din),
      .imm(is_immediate(kind)), .load(cmp_load), .act(act_v[c])
    );

    mpt_wave u_wave (
      .clk(clk), .rst(rst), .tick(tick), .kind(kind), .om(om), .tog_en(tog),
      .hit(hit_v[c]), .hit_top(hit_top), .at_top(at_top), .up_next(up_next),
      .pin(pin_v[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
      match_a  <= 1'b0;
      match_b  <= 1'b0;
    end else begin
      ovf_flag <= tick & evt_ovf;
      match_a  <= tick & hit_v[0];
      match_b  <= tick & hit_v[1];
    end
  end

  assign wave_a = pin_v[0];
  assign wave_b = pin_v[1];
endmodule

// File: rtl/mpt_pwm_timer_chk.sv
module mpt_pwm_timer_chk import mpt_pkg::*; #(
  parameter int W = CNT_W
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input kind_t        kind,
  input logic [W-1:0] cnt,
  input logic         down,
  input logic [W-1:0] top_val,
  input logic [W-1:0] act_a,
  input logic [1:0]   com_a,
  input logic         wave_a,
  input logic         wave_b,
  input logic         ovf_flag,
  input logic         match_a,
  input logic         match_b
);
  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(cnt) && $stable(wave_a) && $stable(wave_b) &&
               !ovf_flag && !match_a && !match_b));

  // R7
  match_src_chk: assert property (@(posedge clk) disable iff (rst)
    match_a |-> ($past(tick) && ($past(cnt) == $past(act_a))));

  // R4
  fast_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && kind == K_FAST && $past(kind) == K_FAST) |->
      ($past(cnt) == $past(top_val)));

  // R2
  max_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && kind == K_NORM && $past(kind) == K_NORM) |-> ($past(cnt) == '1));

  // R5
  dual_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && is_dual(kind) && cnt == top_val && top_val != '0) |=> down);

  // R12
  full_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && is_dual(kind) && com_a[1] && act_a == top_val) |=>
      (wave_a == ~$past(com_a[0])));
endmodule

bind mpt_pwm_timer mpt_pwm_timer_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .kind(kind), .cnt(cnt_q), .down(cnt_down),
  .top_val(top_val), .act_a(cmp_a_act), .com_a(out_mode_a), .wave_a(wave_a),
  .wave_b(wave_b), .ovf_flag(ovf_flag), .match_a(match_a), .match_b(match_b)
);

// File: tb/test_mpt_pwm_timer.sv
`timescale 1ns/100ps
module test_mpt_pwm_timer;
  logic clk = 1'b0;
  logic rst = 1'b1, tick = 1'b0;
  logic [3:0] mode = '0;
  logic [1:0] out_mode_a = '0, out_mode_b = '0;
  logic cmp_a_we = 0, cmp_b_we = 0, cap_top_we = 0;
  logic [15:0] cmp_a_data = '0, cmp_b_data = '0, cap_top_data = '0;
  logic wave_a, wave_b, ovf_flag, match_a, match_b;

  always #2.5 clk = ~clk;

  mpt_pwm_timer i_mpt_pwm_timer (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode),
    .out_mode_a(out_mode_a), .out_mode_b(out_mode_b),
    .cmp_a_we(cmp_a_we), .cmp_a_data(cmp_a_data),
    .cmp_b_we(cmp_b_we), .cmp_b_data(cmp_b_data),
    .cap_top_we(cap_top_we), .cap_top_data(cap_top_data),
    .wave_a(wave_a), .wave_b(wave_b), .ovf_flag(ovf_flag),
    .match_a(match_a), .match_b(match_b)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- bench model ----------------
  logic [15:0] m_cnt, m_hold_a, m_hold_b, m_act_a, m_act_b, m_cap;
  logic m_down, e_wa, e_wb, e_ovf, e_ma, e_mb;

  function automatic int kind_f(input logic [3:0] m);
    if (m == 4 || m == 12) return 1;
    if (m inside {4'd5, 4'd6, 4'd7, 4'd14, 4'd15}) return 2;
    if (m inside {4'd1, 4'd2, 4'd3, 4'd10, 4'd11}) return 3;
    if (m == 8 || m == 9) return 4;
    return 0;
  endfunction

  function automatic logic [15:0] top_f(input logic [3:0] m, input logic [15:0] ca, input logic [15:0] cap);
    case (m)
      4'd1, 4'd5: return 16'h00FF;
      4'd2, 4'd6: return 16'h01FF;
      4'd3, 4'd7: return 16'h03FF;
      4'd4, 4'd9, 4'd11, 4'd15: return ca;
      4'd8, 4'd10, 4'd12, 4'd14: return cap;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic wave_f(input int k, input logic [1:0] om, input logic togok,
                                  input logic p, input logic hit, input logic attop,
                                  input logic up, input logic eqtop);
    logic r;
    r = p;
    if (k <= 1) begin
      if (hit) begin
        if (om == 1) r = !p;
        else if (om == 2) r = 1'b0;
        else if (om == 3) r = 1'b1;
      end
    end else if (k == 2) begin
      if (om == 2) begin if (attop) r = 1'b1; else if (hit) r = 1'b0; end
      else if (om == 3) begin if (attop) r = 1'b0; else if (hit) r = 1'b1; end
    end else begin
      if (om >= 2 && eqtop) r = (om == 2);
      else if (om == 2 && hit) r = !up;
      else if (om == 3 && hit) r = up;
      else if (om == 1 && togok && hit) r = !p;
    end
    return r;
  endfunction

  task automatic model_edge();
    int k;
    logic [15:0] t;
    logic up, ha, hb, at, ld;
    if (rst) begin
      m_cnt = 0; m_hold_a = 0; m_hold_b = 0; m_act_a = 0; m_act_b = 0; m_cap = 0;
      m_down = 0; e_wa = 0; e_wb = 0; e_ovf = 0; e_ma = 0; e_mb = 0;
      return;
    end
    k = kind_f(mode);
    t = top_f(mode, m_act_a, m_cap);
    e_ovf = 0; e_ma = 0; e_mb = 0; ld = 0;
    if (tick) begin
      ha = (m_cnt == m_act_a);
      hb = (m_cnt == m_act_b);
      at = (m_cnt == t);
      if (k >= 3) up = (m_cnt >= t) ? 1'b0 : (m_cnt == 0) ? 1'b1 : !m_down;
      else up = 1'b1;
      e_ovf = (k <= 1) ? (m_cnt == 16'hFFFF) : (k == 2) ? at : (m_cnt == 0);
      e_ma = ha; e_mb = hb;
      e_wa = wave_f(k, out_mode_a, (mode >= 8 && mode <= 11), e_wa, ha, at, up, m_act_a == t);
      e_wb = wave_f(k, out_mode_b, 1'b0, e_wb, hb, at, up, m_act_b == t);
      ld = ((k == 2 || k == 3) && at) || (k == 4 && m_cnt == 0);
      if (k >= 3) begin
        if (up) m_cnt = m_cnt + 1;
        else if (m_cnt != 0) m_cnt = m_cnt - 1;
        m_down = !up;
      end else begin
        m_cnt = at ? 16'h0 : m_cnt + 1;
        m_down = 0;
      end
    end
    if (k <= 1) begin
      m_act_a = cmp_a_we ? cmp_a_data : m_hold_a;
      m_act_b = cmp_b_we ? cmp_b_data : m_hold_b;
    end else if (ld) begin
      m_act_a = m_hold_a;
      m_act_b = m_hold_b;
    end
    if (cmp_a_we) m_hold_a = cmp_a_data;
    if (cmp_b_we) m_hold_b = cmp_b_data;
    if (cap_top_we) m_cap = cap_top_data;
  endtask

  function automatic string wave_tag(input int k);
    return (k <= 1) ? "R8" : (k == 2) ? "R9" : "R10";
  endfunction
  function automatic string ovf_tag(input int k);
    return (k == 0) ? "R2" : (k == 1) ? "R3" : (k == 2) ? "R4" : "R5";
  endfunction

  task automatic step();
    int k;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    cmp_a_we = 0; cmp_b_we = 0; cap_top_we = 0;
    k = kind_f(mode);
    if (!rst) begin
      chk(wave_a == e_wa, wave_tag(k), wave_a, e_wa);
      chk(wave_b == e_wb, wave_tag(k), wave_b, e_wb);
      chk(ovf_flag == e_ovf, ovf_tag(k), ovf_flag, e_ovf);
      chk(match_a == e_ma, "R7", match_a, e_ma);
      chk(match_b == e_mb, "R7", match_b, e_mb);
    end
  endtask

  task automatic do_reset(input logic [3:0] m, input logic [1:0] oa, input logic [1:0] ob);
    mode = m; out_mode_a = oa; out_mode_b = ob;
    rst = 1; tick = 0;
    step(); step();
    rst = 0;
  endtask

  task automatic wr(input bit wa, input logic [15:0] va, input bit wb, input logic [15:0] vb,
                    input bit wc, input logic [15:0] vc);
    tick = 0;
    cmp_a_we = wa; cmp_a_data = va;
    cmp_b_we = wb; cmp_b_data = vb;
    cap_top_we = wc; cap_top_data = vc;
    step();
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ovf_at [3];
    int n, cnt_hi, tog;
    logic prev;
    void'($urandom(32'd20240611));
    @(negedge clk);

    // R1: reset state
    do_reset(4'd0, 2'd0, 2'd0);
    chk({wave_a, wave_b, ovf_flag, match_a, match_b} == 5'b0, "R1",
        {wave_a, wave_b, ovf_flag, match_a, match_b}, 0);

    // R2: full wrap in mode 0, overflow after the tick at 0xFFFF
    n = 0;
    for (int k = 1; k <= 65540; k++) begin
      tick = 1; step();
      if (ovf_flag && n == 0) n = k;
    end
    chk(n == 65536, "R2", n, 65536);

    // R4 R6 R9: fast PWM mode 5, compare A = 63, output mode 2
    do_reset(4'd5, 2'd2, 2'd0);
    wr(1, 16'd63, 0, 0, 0, 0);
    n = 0; cnt_hi = 0;
    for (int k = 1; k <= 800; k++) begin
      tick = 1; step();
      if (ovf_flag && n < 2) begin ovf_at[n] = k; n++; end
      if (k == 64)  chk(match_a == 1'b0, "R6", match_a, 0);
      if (k == 320) chk(match_a == 1'b1, "R6", match_a, 1);
      if (k >= 513 && k <= 768) cnt_hi += wave_a;
    end
    chk(ovf_at[0] == 256, "R4", ovf_at[0], 256);
    chk(ovf_at[1] - ovf_at[0] == 256, "R4", ovf_at[1] - ovf_at[0], 256);
    chk(cnt_hi == 64, "R9", cnt_hi, 64);

    // R13: tick low holds everything
    prev = wave_a;
    for (int k = 0; k < 20; k++) begin
      tick = 0; step();
      chk(wave_a == prev && !ovf_flag && !match_a && !match_b, "R13",
          {wave_a, ovf_flag, match_a, match_b}, {prev, 3'b000});
    end

    // R5 R10: dual slope mode 1, compare A = 100, output mode 2
    do_reset(4'd1, 2'd2, 2'd0);
    wr(1, 16'd100, 0, 0, 0, 0);
    n = 0; cnt_hi = 0;
    for (int k = 1; k <= 1100; k++) begin
      tick = 1; step();
      if (ovf_flag && n < 3) begin ovf_at[n] = k; n++; end
      if (k >= 511 && k <= 1020) cnt_hi += wave_a;
    end
    chk(ovf_at[0] == 1, "R5", ovf_at[0], 1);
    chk(ovf_at[2] - ovf_at[1] == 510, "R5", ovf_at[2] - ovf_at[1], 510);
    chk(cnt_hi == 200, "R10", cnt_hi, 200);

    // R3 R8: CTC mode 4, top = 9, toggle
    do_reset(4'd4, 2'd1, 2'd0);
    wr(1, 16'd9, 0, 0, 0, 0);
    tog = 0; n = 0; prev = wave_a;
    for (int k = 1; k <= 100; k++) begin
      tick = 1; step();
      if (wave_a != prev) tog++;
      prev = wave_a;
      n += ovf_flag;
    end
    chk(tog == 10, "R8", tog, 10);
    chk(n == 0, "R3", n, 0);

    // R12: compare equals top in mode 1, both polarities
    for (int p = 2; p <= 3; p++) begin
      do_reset(4'd1, 2'(p), 2'd0);
      wr(1, 16'h00FF, 0, 0, 0, 0);
      n = 0;
      for (int k = 1; k <= 1100; k++) begin
        tick = 1; step();
        if (k >= 257 && wave_a != (p == 2)) n++;
      end
      chk(n == 0, "R12", n, 0);
    end

    // R11: output mode 1 in mode 2 leaves both pins alone
    do_reset(4'd2, 2'd1, 2'd1);
    wr(1, 16'd10, 1, 16'd10, 0, 0);
    tog = 0;
    for (int k = 1; k <= 1100; k++) begin
      tick = 1; step();
      tog += wave_a + wave_b;
    end
    chk(tog == 0, "R11", tog, 0);

    // R11: mode 10 toggles channel A only
    do_reset(4'd10, 2'd1, 2'd1);
    wr(1, 16'd20, 1, 16'd20, 1, 16'd50);
    tog = 0; n = 0; prev = 0;
    for (int k = 1; k <= 1100; k++) begin
      tick = 1; step();
      if (k > 100 && wave_a != prev) tog++;
      prev = wave_a;
      n += wave_b;
    end
    chk(tog == 20, "R11", tog, 20);
    chk(n == 0, "R11", n, 0);

    // random runs over all modes, checked every cycle against the model
    for (int run = 0; run < 14; run++) begin
      do_reset(4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
      wr(1, 16'($urandom_range(30, 500)), 1, 16'($urandom_range(0, 500)),
         1, 16'($urandom_range(30, 500)));
      for (int k = 0; k < 3000; k++) begin
        tick = ($urandom_range(0, 3) != 0);
        cmp_a_we = ($urandom_range(0, 63) == 0);
        cmp_a_data = 16'($urandom_range(20, 600));
        cmp_b_we = ($urandom_range(0, 63) == 0);
        cmp_b_data = 16'($urandom_range(0, 600));
        cap_top_we = ($urandom_range(0, 63) == 0);
        cap_top_data = 16'($urandom_range(20, 600));
        step();
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule